// File: doc/BRIEF.md
# Latched Maskable Interrupt Controller

This block collects interrupt events for a small 8-bit microcontroller. It has six sources: a 128-tick timer, a 1024-tick timer, USB endpoint 0, USB endpoint 1, general-purpose I/O and an external-capacitor pin. Each source owns a pending latch. A one-cycle event pulse sets the latch, and the latch stays set until the CPU services that source or a reset arrives. An event is latched even while its source is disabled, so turning the source on later raises an interrupt that was already held.

Software reaches an 8-bit enable register at I/O address 0x20 through a simple read/write port. The controller picks a source only on an instruction-boundary strobe. It then takes the highest-priority source that is both pending and enabled and holds that source's index on a registered vector output until the CPU acknowledges it. The acknowledge clears only that source's latch. A global enable input from the CPU masks the request line and leaves the latches alone.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset the enable register reads 0x00, no latch is pending and `irq_req` is 0.
- R2: A write with `io_wr`=1 and `io_addr`=0x20 loads the enable register with `io_wdata & 0xDE`. Bits 0 and 5 are reserved: they read as 0 and writes to them are ignored. A write to any other address changes nothing. `io_rdata` shows the enable register combinationally while `io_rd`=1 and `io_addr`=0x20, and shows 0x00 at all other times.
- R3: Event bit `evt[i]` sets pending latch i whatever the state of enable bit i. A latch that was set while disabled produces a request once its enable bit is written to 1.
- R4: A source is captured only in a cycle where `instr_done`=1, `gie`=1, no capture is outstanding and some source is both pending and enabled. `irq_req` rises one cycle after that edge.
- R5: The event and enable bit positions are: 1 for the 128-tick timer, 2 for the 1024-tick timer, 3 for endpoint 0, 4 for endpoint 1, 6 for GPIO and 7 for the external-capacitor pin. Among the candidates, the lowest bit position wins, and `irq_vec` equals that bit position.
- R6: While a capture is outstanding, `irq_vec` and the capture stay unchanged until `irq_ack`, even if a higher-priority source becomes pending.
- R7: `irq_ack`=1 while a capture is outstanding clears only the captured source's latch and ends the capture at the next edge. Other latches keep their state. An acknowledge with no capture outstanding has no effect.
- R8: If an event for the captured source arrives in the same cycle as its acknowledge, that latch stays set.
- R9: While `gie`=0, `irq_req` is 0 and no new capture occurs. Pending latches and an outstanding capture are kept, and `irq_req` returns when `gie` goes back to 1.
- R10: Event bits 0 and 5 are ignored and never produce a request, even with all enable bits written to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rd | input | 1 | I/O read strobe |
| io_rdata | output | 8 | I/O read data (enable register or 0) |
| evt | input | 8 | One-cycle event pulses, one per bit position |
| gie | input | 1 | Global interrupt enable from the CPU |
| instr_done | input | 1 | Instruction-boundary strobe |
| irq_ack | input | 1 | CPU acknowledge of the presented vector |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 3 | Bit position of the captured source |

## Verification
`io_rdata` is combinational, so the bench checks it in the same cycle that the read is driven. An event or an enable write takes effect at the next rising edge. A capture at a boundary edge shows on `irq_req` and `irq_vec` right after that edge, and an acknowledge drops the request after the edge where it was sampled. The bench drives its inputs just after the falling edge and compares the outputs 2 ns later against a cycle model that it steps at each rising edge. Every check therefore falls inside a settled half-cycle, with the number of register stages counted in the model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC = 8;
    localparam int AW   = 8;
    localparam int DW   = 8;
    localparam int VW   = $clog2(NSRC);

    localparam logic [AW-1:0]   EN_ADDR  = 8'h20;
    localparam logic [NSRC-1:0] SRC_MASK = 8'b1101_1110;

    typedef struct packed {
        logic          hit;
        logic [VW-1:0] idx;
    } grant_t;

    // lowest set bit wins
    function automatic grant_t pick_lowest(input logic [NSRC-1:0] c);
        grant_t g;
        g.hit = 1'b0;
        g.idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (c[i]) begin
                g.hit = 1'b1;
                g.idx = i[VW-1:0];
            end
        end
        return g;
    endfunction
endpackage

// File: rtl/irq_en_reg.sv
module irq_en_reg
    import irq_pkg::*;
#(
    parameter int                AW_P   = AW,
    parameter int                DW_P   = DW,
    parameter logic [AW_P-1:0]   ADDR_P = EN_ADDR,
    parameter logic [DW_P-1:0]   MASK_P = SRC_MASK
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW_P-1:0] io_addr,
    input  logic            io_wr,
    input  logic [DW_P-1:0] io_wdata,
    input  logic            io_rd,
    output logic [DW_P-1:0] io_rdata,
    output logic [DW_P-1:0] en
);
    logic hit;
    assign hit = (io_addr == ADDR_P);

    always_ff @(posedge clk) begin
        if (rst)               en <= '0;
        else if (io_wr && hit) en <= io_wdata & MASK_P;
    end

    assign io_rdata = (io_rd && hit) ? en : '0;

    assert_write_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && hit) |=> (en == ($past(io_wdata) & MASK_P)));
    assert_nowrite_R2: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && hit) |=> $stable(en));
endmodule

// File: rtl/irq_pend.sv
module irq_pend
    import irq_pkg::*;
#(
    parameter int               N_P    = NSRC,
    parameter logic [N_P-1:0]   MASK_P = SRC_MASK
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N_P-1:0] evt,
    input  logic [N_P-1:0] clr,
    output logic [N_P-1:0] pend
);
    for (genvar i = 0; i < N_P; i++) begin : g_bit
        if (MASK_P[i]) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) pend[i] <= 1'b0;
                else     pend[i] <= (pend[i] & ~clr[i]) | evt[i];
            end

            assert_set_R3: assert property (@(posedge clk) disable iff (rst)
                evt[i] |=> pend[i]);
            assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
                (clr[i] && !evt[i]) |=> !pend[i]);
            assert_keep_R7: assert property (@(posedge clk) disable iff (rst)
                (pend[i] && !clr[i]) |=> pend[i]);
        end else begin : g_resv
            assign pend[i] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int N_P  = NSRC,
    parameter int VW_P = VW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_P-1:0]  cand,
    input  logic            boundary,
    input  logic            gie,
    input  logic            ack,
    output logic            valid,
    output logic [VW_P-1:0] idx,
    output logic [N_P-1:0]  clr
);
    grant_t win;
    logic   take;

    assign win  = pick_lowest(cand);
    assign take = !valid && boundary && gie && win.hit;
    assign clr  = (valid && ack) ? (N_P'(1) << idx) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            idx   <= '0;
        end else if (valid && ack) begin
            valid <= 1'b0;
        end else if (take) begin
            valid <= 1'b1;
            idx   <= win.idx;
        end
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && !ack) |=> (valid && $stable(idx)));
    assert_boundary_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> ($past(boundary) && $past(gie)));
    assert_pick_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> ((($past(cand) >> idx) & N_P'(1)) == N_P'(1)));
    assert_first_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(valid) |-> (($past(cand) & ((N_P'(1) << idx) - N_P'(1))) == '0));
    assert_clr_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] io_addr,
    input  logic          io_wr,
    input  logic [DW-1:0] io_wdata,
    input  logic          io_rd,
    output logic [DW-1:0] io_rdata,
    input  logic [NSRC-1:0] evt,
    input  logic          gie,
    input  logic          instr_done,
    input  logic          irq_ack,
    output logic          irq_req,
    output logic [VW-1:0] irq_vec
);
    logic [NSRC-1:0] en, pend, clr, cand;
    logic            valid;

    irq_en_reg u_en (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata), .en(en)
    );

    irq_pend u_pend (
        .clk(clk), .rst(rst), .evt(evt), .clr(clr), .pend(pend)
    );

    assign cand = pend & en;

    irq_arb u_arb (
        .clk(clk), .rst(rst), .cand(cand), .boundary(instr_done), .gie(gie),
        .ack(irq_ack), .valid(valid), .idx(irq_vec), .clr(clr)
    );

    assign irq_req = valid && gie;

    assert_gie_R9: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq_req);
    assert_resv_R10: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_vec != 3'd0 && irq_vec != 3'd5));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] io_addr = '0, io_wdata = '0, evt = '0;
    logic       io_wr = 1'b0, io_rd = 1'b0, gie = 1'b0, instr_done = 1'b0, irq_ack = 1'b0;
    logic [7:0] io_rdata;
    logic       irq_req;
    logic [2:0] irq_vec;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state
    logic [7:0] m_en = '0, m_pend = '0;
    logic       m_v = 1'b0;
    logic [2:0] m_vec = '0;

    always #10 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rd(io_rd), .io_rdata(io_rdata), .evt(evt), .gie(gie),
        .instr_done(instr_done), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [3:0] lowest(input logic [7:0] c);
        for (int i = 0; i < 8; i++) if (c[i]) return {1'b1, 3'(i)};
        return 4'd0;
    endfunction

    task automatic idle();
        io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = 0;
        evt = 0; instr_done = 0; irq_ack = 0;
    endtask

    // inputs are set by the caller right after a falling edge
    task automatic cyc();
        logic [7:0] clrv, cnd;
        logic [3:0] w;
        #2;
        check("R4 req", irq_req, m_v && gie);
        if (m_v) check("R5 vec", irq_vec, m_vec);
        check("R2 rdata", io_rdata, (io_rd && io_addr == 8'h20) ? m_en : 8'h00);
        @(posedge clk);
        clrv = (m_v && irq_ack) ? (8'd1 << m_vec) : 8'd0;
        cnd  = m_pend & m_en;
        w    = lowest(cnd);
        m_pend = ((m_pend & ~clrv) | evt) & 8'hDE;
        if (m_v && irq_ack) m_v = 1'b0;
        else if (!m_v && instr_done && gie && w[3]) begin
            m_v = 1'b1; m_vec = w[2:0];
        end
        if (io_wr && io_addr == 8'h20) m_en = io_wdata & 8'hDE;
        @(negedge clk);
    endtask

    task automatic wr_en(input logic [7:0] a, input logic [7:0] d);
        idle(); io_wr = 1; io_addr = a; io_wdata = d; cyc(); idle();
    endtask

    task automatic boundary();
        idle(); instr_done = 1; cyc(); idle();
    endtask

    task automatic acknowledge();
        idle(); irq_ack = 1; cyc(); idle();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 req", irq_req, 0);
        idle(); io_rd = 1; io_addr = 8'h20; #2; check("R1 en", io_rdata, 8'h00);
        cyc(); idle();
        gie = 1;

        // R2 reserved bits and foreign address
        wr_en(8'h20, 8'hFF);
        io_rd = 1; io_addr = 8'h20; #2; check("R2 mask", io_rdata, 8'hDE); cyc(); idle();
        wr_en(8'h21, 8'h55);
        io_rd = 1; io_addr = 8'h20; #2; check("R2 other addr", io_rdata, 8'hDE); cyc(); idle();
        io_rd = 1; io_addr = 8'h21; #2; check("R2 read other", io_rdata, 8'h00); cyc(); idle();
        wr_en(8'h20, 8'h00);

        // R3 latch while disabled, then enable
        evt = 8'h08; cyc(); idle();
        boundary(); boundary();
        check("R3 disabled", irq_req, 0);
        wr_en(8'h20, 8'h08);
        boundary();
        check("R3 req", irq_req, 1); check("R3 vec", irq_vec, 3);

        // R6 hold despite higher priority
        wr_en(8'h20, 8'hDE);
        evt = 8'h02; cyc(); idle();
        boundary();
        check("R6 vec", irq_vec, 3); check("R6 req", irq_req, 1);

        // R7 ack clears only the selected latch
        acknowledge();
        check("R7 drop", irq_req, 0);
        boundary();
        check("R7 other kept", irq_vec, 1); check("R7 req", irq_req, 1);
        acknowledge(); boundary();
        check("R7 none left", irq_req, 0);
        acknowledge(); boundary();
        check("R7 stray ack", irq_req, 0);

        // R8 event coincident with its clear
        evt = 8'h02; cyc(); idle(); boundary();
        irq_ack = 1; evt = 8'h02; cyc(); idle();
        boundary();
        check("R8 req", irq_req, 1); check("R8 vec", irq_vec, 1);
        acknowledge();

        // R5 priority sweep
        evt = 8'hD8; cyc(); idle();
        boundary(); check("R5 ep0", irq_vec, 3); acknowledge();
        boundary(); check("R5 ep1", irq_vec, 4); acknowledge();
        boundary(); check("R5 gpio", irq_vec, 6); acknowledge();
        boundary(); check("R5 cext", irq_vec, 7); acknowledge();
        evt = 8'h06; cyc(); idle();
        boundary(); check("R5 t128", irq_vec, 1); acknowledge();
        boundary(); check("R5 t1024", irq_vec, 2); acknowledge();

        // R4 no capture without boundary
        evt = 8'h04; cyc(); idle(); cyc(); cyc();
        check("R4 no boundary", irq_req, 0);
        boundary(); check("R4 boundary", irq_req, 1);
        acknowledge();

        // R9 global enable
        gie = 0;
        evt = 8'h10; cyc(); idle(); boundary(); boundary();
        check("R9 masked", irq_req, 0);
        gie = 1; boundary();
        check("R9 kept", irq_req, 1); check("R9 vec", irq_vec, 4);
        gie = 0; #2; check("R9 mask held", irq_req, 0);
        gie = 1; #2; check("R9 unmask", irq_req, 1); check("R9 vec held", irq_vec, 4);
        acknowledge();

        // R10 reserved events
        wr_en(8'h20, 8'hFF);
        evt = 8'h21; cyc(); idle(); boundary(); boundary();
        check("R10 reserved", irq_req, 0);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            idle();
            evt        = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            instr_done = ($urandom % 3 == 0);
            irq_ack    = ($urandom % 3 == 0);
            gie        = ($urandom % 10 != 0);
            io_rd      = ($urandom % 4 == 0);
            io_wr      = ($urandom % 25 == 0);
            io_addr    = ($urandom % 2 == 0) ? 8'h20 : 8'($urandom);
            io_wdata   = 8'($urandom);
            cyc();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule